// File: doc/BRIEF.md
# I2C Pad Drive Mode Controller

This block sits between an I2C master's protocol engine and the chip pads. The engine only says "pull SCL low" and "pull SDA low". This block turns those two requests into pad controls: an output value and an output enable for each bus line, plus a separate output pin for each line, used when outputs are split from inputs. Which pad controls are produced depends on one of four pin modes.

- **Open-drain:** the default mode.
- **Ultra-fast push-pull:** outputs only.
- **Two-wire push-pull:** handles clock stretching and data direction per pulse.
- **Four-wire push-pull:** the bus pads act only as inputs, and the separate pins carry the outputs with a polarity that can be inverted.

The mode, the ignore-NACK setting and the two polarity bits are captured in every cycle in which the master is disabled. They are frozen while it is enabled. The protocol engine supplies three things:

- the index of the current clock pulse within the byte: 1 to 9, with 0 outside a byte;
- a flag that is high when the master is receiving;
- an enable.

While the master is disabled, all pads are released.

Top module: `i2c_pad_mode_ctrl`

## Requirements
- R1: After reset the active mode is open-drain (`mode_active` = 0) and `cfg_err` = 0. Both pad enables are 0, both pad values are 0, and each separate output sits at its idle level (the inverse of its latched polarity bit, which resets to 0).
- R2: Mode request encoding: 0 open-drain, 1 ultra-fast push-pull, 2 two-wire push-pull, 3 four-wire push-pull. The request, `ignore_nack`, `inv_scls` and `inv_sdas` are captured at each clock edge where `master_en` = 0. While `master_en` = 1, changes to them have no effect on `mode_active`, `cfg_err` or any output.
- R3: While `master_en` = 0, `scl_oe` = `sda_oe` = 0, `scl_o` = `sda_o` = 0, and each separate output equals the inverse of its latched polarity bit.
- R4: Open-drain mode, enabled: each pad enable equals its drive-low request and each pad value is 0.
- R5: Ultra-fast push-pull mode, enabled: both pad enables are 1 and each pad value is the inverse of its drive-low request.
- R6: A captured request for mode 1 with `ignore_nack` = 0 sets `cfg_err` = 1 and makes the active mode open-drain (0). The next capture of a valid configuration clears `cfg_err`.
- R7: Two-wire push-pull mode, enabled: on pulse index 9, SCL behaves as open-drain (enable = request, value 0). On every other index it is driven push-pull (enable 1, value = inverse of request).
- R8: Two-wire push-pull mode, enabled: SDA is tristated (enable 0, value 0) when `master_rx` = 1 and the pulse index is 1 to 8, and when `master_rx` = 0 and the index is 9. Otherwise SDA is driven push-pull.
- R9: Four-wire mode, enabled: both pad enables and values are 0. `scls_o` = (NOT `scl_drive_low`) XOR latched `inv_scls`, and `sdas_o` = (NOT `sda_drive_low`) XOR latched `inv_sdas`.
- R10: In modes 0 to 2 the separate outputs stay at their idle level (inverse of the latched polarity bit), whatever the drive requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master enabled; configuration frozen while high |
| mode_req | input | 2 | Requested pin mode (encoding in R2) |
| ignore_nack | input | 1 | Ignore-NACK setting, needed for ultra-fast mode |
| inv_scls | input | 1 | Polarity inversion for the separate SCL output |
| inv_sdas | input | 1 | Polarity inversion for the separate SDA output |
| scl_drive_low | input | 1 | Engine request to pull SCL low |
| sda_drive_low | input | 1 | Engine request to pull SDA low |
| master_rx | input | 1 | High while the master receives data |
| pulse_idx | input | 4 | Clock pulse index within the byte (1..9, 0 outside) |
| scl_o | output | 1 | SCL pad output value |
| scl_oe | output | 1 | SCL pad output enable |
| sda_o | output | 1 | SDA pad output value |
| sda_oe | output | 1 | SDA pad output enable |
| scls_o | output | 1 | Separate SCL output pin |
| sdas_o | output | 1 | Separate SDA output pin |
| cfg_err | output | 1 | Invalid configuration captured |
| mode_active | output | 2 | Mode currently in force |

## Verification
The bench sweeps every pulse index from 0 to 9 against both directions in two-wire mode, because the boundaries at index 0, index 8 and index 9 are where a wrong comparison hides. A design with an off-by-one there would float SDA on a transmit data bit, or release SCL on a data clock. The bench also changes the mode request while the master is enabled; a design that re-captures it would switch pad behaviour in the middle of a transfer. Finally, it requests ultra-fast mode without ignore-NACK. A design without the fallback would drive the bus push-pull during an ACK slot instead of reporting `cfg_err` and staying open-drain.

// File: rtl/i2c_pad_pkg.sv
package i2c_pad_pkg;

  typedef enum logic [1:0] {
    PM_OPEN_DRAIN = 2'd0,
    PM_ULTRA_PP   = 2'd1,
    PM_PP_2WIRE   = 2'd2,
    PM_PP_4WIRE   = 2'd3
  } pad_mode_e;

  // SCL goes open-drain on the acknowledge pulse in two-wire mode
  function automatic logic scl_stretch_slot(input logic [3:0] idx, input logic [3:0] ack);
    return idx == ack;
  endfunction

  // SDA floats for received data bits and for the transmit ACK slot
  function automatic logic sda_float_slot(input logic [3:0] idx, input logic rx,
                                          input logic [3:0] ack);
    if (rx) return (idx != 4'd0) && (idx < ack);
    return idx == ack;
  endfunction

endpackage

// File: rtl/pad_mode_cfg.sv
module pad_mode_cfg
  import i2c_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      master_en,
  input  logic [1:0] mode_req,
  input  logic      ignore_nack,
  input  logic      inv_scls,
  input  logic      inv_sdas,
  output pad_mode_e mode_q,
  output logic      inv_scls_q,
  output logic      inv_sdas_q,
  output logic      cfg_err_q
);

  logic cfg_capture;
  logic cfg_invalid;

  assign cfg_capture = !master_en;
  assign cfg_invalid = (pad_mode_e'(mode_req) == PM_ULTRA_PP) && !ignore_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PM_OPEN_DRAIN;
      inv_scls_q <= 1'b0;
      inv_sdas_q <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else if (cfg_capture) begin
      mode_q     <= cfg_invalid ? PM_OPEN_DRAIN : pad_mode_e'(mode_req);
      inv_scls_q <= inv_scls;
      inv_sdas_q <= inv_sdas;
      cfg_err_q  <= cfg_invalid;
    end
  end

  // R2: configuration frozen while enabled
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_en |=> $stable(mode_q) && $stable(cfg_err_q));

  // R6: an error always comes with the open-drain fallback
  assert_err_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_q |-> mode_q == PM_OPEN_DRAIN);

endmodule

// File: rtl/pad_line_mux.sv
module pad_line_mux
  import i2c_pad_pkg::*;
#(
  parameter bit IS_CLK    = 1'b1,
  parameter int IDX_W     = 4,
  parameter int ACK_PULSE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pad_mode_e        mode,
  input  logic             en,
  input  logic             drive_low,
  input  logic             master_rx,
  input  logic [IDX_W-1:0] pulse_idx,
  input  logic             inv,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             sep_o
);

  localparam logic [3:0] ACK_IDX = 4'(ACK_PULSE);

  logic [3:0] idx4;
  logic       pp2_relax;

  assign idx4 = 4'(pulse_idx);

  generate
    if (IS_CLK) begin : g_clk_rule
      assign pp2_relax = scl_stretch_slot(idx4, ACK_IDX);
    end else begin : g_dat_rule
      assign pp2_relax = sda_float_slot(idx4, master_rx, ACK_IDX);
    end
  endgenerate

  always_comb begin
    pad_o  = 1'b0;
    pad_oe = 1'b0;
    sep_o  = ~inv;
    if (en) begin
      unique case (mode)
        PM_OPEN_DRAIN: pad_oe = drive_low;
        PM_ULTRA_PP: begin
          pad_oe = 1'b1;
          pad_o  = ~drive_low;
        end
        PM_PP_2WIRE: begin
          if (pp2_relax) begin
            pad_oe = IS_CLK ? drive_low : 1'b0;
          end else begin
            pad_oe = 1'b1;
            pad_o  = ~drive_low;
          end
        end
        PM_PP_4WIRE: sep_o = (~drive_low) ^ inv;
        default: pad_oe = drive_low;
      endcase
    end
  end

  // R3: released while disabled
  assert_released_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pad_oe && !pad_o);

  // R9: pads are inputs only in four-wire mode
  assert_inputs_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_PP_4WIRE) |-> !pad_oe);

  // R5: ultra-fast always drives
  assert_uf_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == PM_ULTRA_PP) |-> pad_oe);

  // R4: open-drain never drives high
  assert_od_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == PM_OPEN_DRAIN) |-> !pad_o);

  // R10: separate output idle outside four-wire mode
  assert_sep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PM_PP_4WIRE) |-> sep_o == ~inv);

endmodule

// File: rtl/i2c_pad_mode_ctrl.sv
module i2c_pad_mode_ctrl
  import i2c_pad_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int ACK_PULSE = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic [1:0]       mode_req,
  input  logic             ignore_nack,
  input  logic             inv_scls,
  input  logic             inv_sdas,
  input  logic             scl_drive_low,
  input  logic             sda_drive_low,
  input  logic             master_rx,
  input  logic [IDX_W-1:0] pulse_idx,
  output logic             scl_o,
  output logic             scl_oe,
  output logic             sda_o,
  output logic             sda_oe,
  output logic             scls_o,
  output logic             sdas_o,
  output logic             cfg_err,
  output logic [1:0]       mode_active
);

  localparam int NLINES = 2;  // line 0 = SCL, line 1 = SDA

  pad_mode_e   mode_q;
  logic        inv_scls_q, inv_sdas_q;
  logic [NLINES-1:0] drv_req, inv_lat, p_o, p_oe, s_o;

  pad_mode_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .mode_req    (mode_req),
    .ignore_nack (ignore_nack),
    .inv_scls    (inv_scls),
    .inv_sdas    (inv_sdas),
    .mode_q      (mode_q),
    .inv_scls_q  (inv_scls_q),
    .inv_sdas_q  (inv_sdas_q),
    .cfg_err_q   (cfg_err)
  );

  assign drv_req = {sda_drive_low, scl_drive_low};
  assign inv_lat = {inv_sdas_q, inv_scls_q};

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_line
      pad_line_mux #(
        .IS_CLK    (g == 0),
        .IDX_W     (IDX_W),
        .ACK_PULSE (ACK_PULSE)
      ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .en        (master_en),
        .drive_low (drv_req[g]),
        .master_rx (master_rx),
        .pulse_idx (pulse_idx),
        .inv       (inv_lat[g]),
        .pad_o     (p_o[g]),
        .pad_oe    (p_oe[g]),
        .sep_o     (s_o[g])
      );
    end
  endgenerate

  assign scl_o       = p_o[0];
  assign scl_oe      = p_oe[0];
  assign sda_o       = p_o[1];
  assign sda_oe      = p_oe[1];
  assign scls_o      = s_o[0];
  assign sdas_o      = s_o[1];
  assign mode_active = mode_q;

  // R7: SCL never driven high on the stretch pulse in two-wire mode
  assert_scl_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && mode_q == PM_PP_2WIRE && pulse_idx == IDX_W'(ACK_PULSE))
      |-> !scl_o && (scl_oe == scl_drive_low));

  // R8: SDA floats while the slave answers in transmit
  assert_sda_ack_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && mode_q == PM_PP_2WIRE && !master_rx && pulse_idx == IDX_W'(ACK_PULSE))
      |-> !sda_oe);

endmodule

// File: tb/tb_i2c_pad_mode_ctrl.sv
module tb_i2c_pad_mode_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 0, ignore_nack = 0, inv_scls = 0, inv_sdas = 0;
  logic scl_drive_low = 0, sda_drive_low = 0, master_rx = 0;
  logic [1:0] mode_req = 0;
  logic [3:0] pulse_idx = 0;
  logic scl_o, scl_oe, sda_o, sda_oe, scls_o, sdas_o, cfg_err;
  logic [1:0] mode_active;

  int checks = 0, errors = 0;
  int m_mode = 0, m_err = 0, m_iscl = 0, m_isda = 0;

  always #5 clk = ~clk;

  i2c_pad_mode_ctrl dut (.*);

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_err = 0; m_iscl = 0; m_isda = 0;
    end else if (!master_en) begin
      m_err  = (mode_req == 1 && !ignore_nack) ? 1 : 0;
      m_mode = m_err ? 0 : int'(mode_req);
      m_iscl = int'(inv_scls);
      m_isda = int'(inv_sdas);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string force_tag);
    int e_sclo, e_scloe, e_sdao, e_sdaoe, e_scls, e_sdas, idx, drc, drd;
    string tc, td, ts;
    idx = int'(pulse_idx); drc = int'(scl_drive_low); drd = int'(sda_drive_low);
    e_sclo = 0; e_scloe = 0; e_sdao = 0; e_sdaoe = 0;
    e_scls = 1 - m_iscl; e_sdas = 1 - m_isda;
    tc = "R3"; td = "R3"; ts = "R10";
    if (master_en) begin
      if (m_mode == 0) begin
        tc = m_err ? "R6" : "R4"; td = tc;
        e_scloe = drc; e_sdaoe = drd;
      end else if (m_mode == 1) begin
        tc = "R5"; td = "R5";
        e_scloe = 1; e_sdaoe = 1; e_sclo = 1 - drc; e_sdao = 1 - drd;
      end else if (m_mode == 2) begin
        tc = "R7"; td = "R8";
        if (idx == 9) e_scloe = drc;
        else begin e_scloe = 1; e_sclo = 1 - drc; end
        if ((master_rx && idx >= 1 && idx <= 8) || (!master_rx && idx == 9)) e_sdaoe = 0;
        else begin e_sdaoe = 1; e_sdao = 1 - drd; end
      end else begin
        tc = "R9"; td = "R9"; ts = "R9";
        e_scls = ((1 - drc) != m_iscl) ? 1 : 0;
        e_sdas = ((1 - drd) != m_isda) ? 1 : 0;
      end
    end
    if (force_tag != "") begin tc = force_tag; td = force_tag; ts = force_tag; end
    chk(force_tag != "" ? force_tag : "R2", "mode_active", int'(mode_active), m_mode);
    chk(force_tag != "" ? force_tag : "R6", "cfg_err", int'(cfg_err), m_err);
    chk(tc, "scl_o", int'(scl_o), e_sclo);
    chk(tc, "scl_oe", int'(scl_oe), e_scloe);
    chk(td, "sda_o", int'(sda_o), e_sdao);
    chk(td, "sda_oe", int'(sda_oe), e_sdaoe);
    chk(ts, "scls_o", int'(scls_o), e_scls);
    chk(ts, "sdas_o", int'(sdas_o), e_sdas);
  endtask

  // compare at the falling edge, then apply the next stimulus
  task automatic step(string tag = "");
    @(negedge clk);
    compare(tag);
  endtask

  task automatic configure(int md, int ign, int isc, int isd);
    step(); master_en = 0; mode_req = 2'(md); ignore_nack = ign[0];
    inv_scls = isc[0]; inv_sdas = isd[0];
    step(); step();
    master_en = 1;
  endtask

  task automatic sweep();
    for (int rx = 0; rx < 2; rx++)
      for (int ix = 0; ix < 10; ix++)
        for (int d = 0; d < 4; d++) begin
          step();
          master_rx = rx[0]; pulse_idx = 4'(ix);
          scl_drive_low = d[0]; sda_drive_low = d[1];
        end
    step();
  endtask

  initial begin
    int cyc = 0;
    fork
      begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : stim
        step("R1"); step("R1");
        @(negedge clk); rst_n = 1;
        step("R1");
        // R4, R5, R7, R8, R9 sweeps with both polarities
        for (int md = 0; md < 4; md++)
          for (int p = 0; p < 2; p++) begin
            configure(md, 1, p, 1 - p);
            sweep();
            // R2: requests changed while enabled must have no effect
            mode_req = 2'((md + 1) % 4); ignore_nack = 0; inv_scls = ~inv_scls;
            repeat (6) begin
              step();
              scl_drive_low = ~scl_drive_low; pulse_idx = 4'((int'(pulse_idx) + 1) % 10);
            end
          end
        // R6: ultra-fast without ignore-NACK falls back to open-drain
        configure(1, 0, 0, 0);
        sweep();
        // R6: valid capture clears the error
        configure(2, 0, 1, 1);
        sweep();
        // R3 / R10: disabled and idle
        master_en = 0;
        repeat (20) begin
          step();
          scl_drive_low = ~scl_drive_low; sda_drive_low = $urandom_range(0, 1);
        end
        // mixed random traffic
        repeat (3000) begin
          step();
          cyc++;
          if ((cyc % 97) == 0) master_en = ~master_en;
          mode_req = 2'($urandom_range(0, 3)); ignore_nack = $urandom_range(0, 1);
          inv_scls = $urandom_range(0, 1); inv_sdas = $urandom_range(0, 1);
          scl_drive_low = $urandom_range(0, 1); sda_drive_low = $urandom_range(0, 1);
          master_rx = $urandom_range(0, 1); pulse_idx = 4'($urandom_range(0, 9));
        end
        step();
        disable watchdog;
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule